// File: doc/BRIEF.md
# Radix-4 Recoded Sequential Signed Multiplier

This block multiplies two N-bit two's complement numbers and returns their 2N-bit two's complement product. It works on the multiplier two bits at a time. Each step takes a window of three multiplier bits: the current pair plus the top bit of the pair before it. The window is recoded into one digit from {-2, -1, 0, +1, +2}. The matching multiple of the multiplicand is added into a sign-extended accumulator, and the accumulator and the multiplier are then shifted right by two places. Negative operands go through the same steps as positive ones. No operand is negated beforehand.

A host pulses `start_i` for one cycle with both operands present. The block raises `busy_o` while it runs N/2 add/shift steps. When the product is ready it pulses `done_o` for one cycle. The product stays on `prod_o` until the next accepted start. Each step does at most one add or subtract, whatever the bit pattern of the multiplier. The accumulator is N+2 bits wide, so twice the most negative multiplicand still fits.

Top module: `radix4_mul`

## Requirements
- R1: After reset, and before any start, `busy_o` and `done_o` are 0 and `prod_o` is 0.
- R2: A `start_i` sampled high while `busy_o` is low is accepted. `busy_o` is high in the following cycle.
- R3: For a start accepted at rising edge e, `done_o` is high only in the cycle after edge e+N/2. `busy_o` is high from after edge e until edge e+N/2.
- R4: When `done_o` is high, `prod_o` equals the signed product of the `mcand_i` and `mplier_i` values sampled with the accepted start. This holds for every operand pair, either sign.
- R5: The window formed by multiplier bits (2k+1, 2k, 2k-1), with bit -1 taken as 0, selects a digit of weight 4^k. The mapping is 000 and 111 to 0, 001 and 010 to +1, 011 to +2, 100 to -2, and 101 and 110 to -1. Alternating patterns such as 0x5555 and 0xAAAA therefore still finish in N/2 steps with the correct product.
- R6: A `start_i` sampled high while `busy_o` is high is ignored. The running product and its timing are not changed.
- R7: While the block is idle and no start is accepted, `prod_o` holds its value.
- R8: `done_o` is a single-cycle pulse, and `busy_o` is low whenever `done_o` is high.
- R9: The most negative operands give the exact result. For example, -2^(N-1) times -2^(N-1) gives 2^(2N-2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a multiply |
| mcand_i | input | N | Signed multiplicand, sampled with an accepted start |
| mplier_i | input | N | Signed multiplier, sampled with an accepted start |
| busy_o | output | 1 | A multiply is in progress |
| done_o | output | 1 | One-cycle pulse: `prod_o` holds a fresh product |
| prod_o | output | 2N | Signed product |

## Verification
`busy_o` is due one edge after the edge that samples the start. `done_o` and the product are due N/2+1 edges after that same edge, so after 9 edges at N=16 and after 3 at N=4. The bench changes its inputs on falling edges and also reads the outputs on falling edges. It counts falling edges from the start, confirms that `done_o` stays low before the expected edge, and checks the product exactly at it. One cycle later it checks that the pulse has ended and that the product is held. Two instances are used. The 4-bit one is run over every operand pair, and the 16-bit one over directed corner cases plus seeded random pairs.

// File: rtl/radix4_mul_pkg.sv
package radix4_mul_pkg;
  // recoded digit: nz=nonzero, dbl=magnitude 2, neg=negative
  typedef struct packed {
    logic neg;
    logic dbl;
    logic nz;
  } r4_digit_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } r4_state_e;
endpackage

// File: rtl/r4_recode.sv
module r4_recode
  import radix4_mul_pkg::*;
(
  input  logic [2:0] grp_i,
  output r4_digit_t  dig_o
);
  always_comb begin
    unique case (grp_i)
      3'b000, 3'b111: dig_o = '{neg: 1'b0, dbl: 1'b0, nz: 1'b0};
      3'b001, 3'b010: dig_o = '{neg: 1'b0, dbl: 1'b0, nz: 1'b1};
      3'b011:         dig_o = '{neg: 1'b0, dbl: 1'b1, nz: 1'b1};
      3'b100:         dig_o = '{neg: 1'b1, dbl: 1'b1, nz: 1'b1};
      default:        dig_o = '{neg: 1'b1, dbl: 1'b0, nz: 1'b1};
    endcase
  end
endmodule

// File: rtl/r4_pp_sel.sv
module r4_pp_sel
  import radix4_mul_pkg::*;
#(
  parameter int N = 16,
  localparam int W = N + 2
) (
  input  logic [N-1:0] mcand_i,
  input  r4_digit_t    dig_i,
  output logic [W-1:0] pp_o,
  output logic         cin_o
);
  logic [W-1:0] mag;

  always_comb begin
    if (!dig_i.nz)      mag = '0;
    else if (dig_i.dbl) mag = {mcand_i[N-1], mcand_i, 1'b0};
    else                mag = {{2{mcand_i[N-1]}}, mcand_i};
    // negate as invert plus carry-in into the accumulator adder
    pp_o  = dig_i.neg ? ~mag : mag;
    cin_o = dig_i.neg & dig_i.nz;
  end
endmodule

// File: rtl/r4_ctrl.sv
module r4_ctrl
  import radix4_mul_pkg::*;
#(
  parameter int STEPS = 8,
  localparam int CW = $clog2(STEPS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  r4_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last   = (cnt_q == CW'(STEPS - 1));
  assign busy_o = (state_q == ST_RUN);
  assign load_o = (state_q == ST_IDLE) && start_i;
  assign step_o = busy_o;

  always_comb begin
    state_d = state_q;
    if (load_o)              state_d = ST_RUN;
    else if (busy_o && last) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= busy_o && last;
      if (load_o)      cnt_q <= '0;
      else if (busy_o) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/radix4_mul.sv
module radix4_mul
  import radix4_mul_pkg::*;
#(
  parameter int N = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [N-1:0]   mcand_i,
  input  logic [N-1:0]   mplier_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [2*N-1:0] prod_o
);
  localparam int W     = N + 2;
  localparam int STEPS = N / 2;

  logic [W-1:0] acc_q;
  logic [N-1:0] mq_q, mc_q;
  logic         qm1_q;
  logic         load, step;
  r4_digit_t    dig;
  logic [W-1:0] pp, sum;
  logic         cin;

  r4_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  r4_recode u_rec (
    .grp_i({mq_q[1:0], qm1_q}),
    .dig_o(dig)
  );

  r4_pp_sel #(.N(N)) u_sel (
    .mcand_i(mc_q),
    .dig_i  (dig),
    .pp_o   (pp),
    .cin_o  (cin)
  );

  assign sum = acc_q + pp + {{(W-1){1'b0}}, cin};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      mq_q  <= '0;
      mc_q  <= '0;
      qm1_q <= 1'b0;
    end else if (load) begin
      acc_q <= '0;
      mq_q  <= mplier_i;
      mc_q  <= mcand_i;
      qm1_q <= 1'b0;
    end else if (step) begin
      // arithmetic shift of {acc, mq} by two places
      acc_q <= {{2{sum[W-1]}}, sum[W-1:2]};
      mq_q  <= {sum[1:0], mq_q[N-1:2]};
      qm1_q <= mq_q[1];
    end
  end

  assign prod_o = {acc_q[N-1:0], mq_q};
endmodule

// File: rtl/radix4_mul_chk.sv
module radix4_mul_chk #(
  parameter int N = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic [N-1:0]   mcand_i,
  input logic [N-1:0]   mplier_i,
  input logic           busy_o,
  input logic           done_o,
  input logic [2*N-1:0] prod_o
);
  localparam int STEPS = N / 2;
  localparam int CW    = $clog2(STEPS + 2);

  logic [CW-1:0]  lat_q;
  logic [N-1:0]   a_q, b_q;
  logic [2*N-1:0] exp_p;
  logic           acc_start;

  assign acc_start = start_i && !busy_o;
  assign exp_p = {{N{a_q[N-1]}}, a_q} * {{N{b_q[N-1]}}, b_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
    end else if (acc_start) begin
      lat_q <= '0;
      a_q   <= mcand_i;
      b_q   <= mplier_i;
    end else if (busy_o) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  p_busy_after_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_start |=> busy_o);

  p_latency_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lat_q == CW'(STEPS)));

  p_done_after_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o));

  // R6 and R9 are covered as well: a_q/b_q only follow accepted starts
  p_product_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (prod_o == exp_p));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(prod_o));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_no_busy_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

bind radix4_mul radix4_mul_chk #(.N(N)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .mcand_i (mcand_i),
  .mplier_i(mplier_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .prod_o  (prod_o)
);

// File: tb/sim_radix4_mul.sv
module sim_radix4_mul;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        st16 = 1'b0, st4 = 1'b0;
  logic [15:0] a16 = '0, b16 = '0;
  logic [3:0]  a4 = '0, b4 = '0;
  logic        busy16, done16, busy4, done4;
  logic [31:0] p16;
  logic [7:0]  p4;

  int total = 0;
  int fails = 0;

  radix4_mul #(.N(16)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(st16), .mcand_i(a16), .mplier_i(b16),
    .busy_o(busy16), .done_o(done16), .prod_o(p16)
  );

  radix4_mul #(.N(4)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(st4), .mcand_i(a4), .mplier_i(b4),
    .busy_o(busy4), .done_o(done4), .prod_o(p4)
  );

  function automatic logic [31:0] ref16(input logic [15:0] a, input logic [15:0] b);
    return {{16{a[15]}}, a} * {{16{b[15]}}, b};
  endfunction

  function automatic logic [7:0] ref4(input logic [3:0] a, input logic [3:0] b);
    return {{4{a[3]}}, a} * {{4{b[3]}}, b};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // full 16-bit multiply with timing checks (R2 R3 R4 R7 R8)
  task automatic mul16(input logic [15:0] a, input logic [15:0] b, input string req);
    logic [31:0] e;
    e = ref16(a, b);
    @(negedge clk); st16 = 1'b1; a16 = a; b16 = b;
    @(negedge clk); st16 = 1'b0;
    chk(busy16 == 1'b1, "R2 busy", 64'(busy16), 64'd1);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (k < 8) chk(done16 == 1'b0, "R3 early done", 64'(done16), 64'd0);
    end
    chk(done16 == 1'b1, "R3 done", 64'(done16), 64'd1);
    chk(busy16 == 1'b0, "R8 busy low with done", 64'(busy16), 64'd0);
    chk(p16 == e, req, 64'(p16), 64'(e));
    @(negedge clk);
    chk(done16 == 1'b0, "R8 pulse", 64'(done16), 64'd0);
    chk(p16 == e, "R7 hold", 64'(p16), 64'(e));
  endtask

  task automatic mul4(input logic [3:0] a, input logic [3:0] b);
    logic [7:0] e;
    e = ref4(a, b);
    @(negedge clk); st4 = 1'b1; a4 = a; b4 = b;
    @(negedge clk); st4 = 1'b0;
    chk(done4 == 1'b0, "R3 early done n4", 64'(done4), 64'd0);
    @(negedge clk);
    @(negedge clk);
    chk(done4 == 1'b1, "R3 done n4", 64'(done4), 64'd1);
    chk(p4 == e, "R4 exhaustive n4", 64'(p4), 64'(e));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    // R1 reset state
    chk(busy16 == 1'b0 && done16 == 1'b0, "R1 flags", {busy16, done16}, 64'd0);
    chk(p16 == 32'd0, "R1 product", 64'(p16), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy16 == 1'b0 && p16 == 32'd0, "R1 after release", 64'(p16), 64'd0);

    mul16(16'd21, 16'd14, "R4 21x14");
    mul16(16'h8000, 16'h8000, "R9 minneg squared");
    mul16(16'h8000, 16'h7FFF, "R9 minneg x maxpos");
    mul16(16'h7FFF, 16'h8000, "R9 maxpos x minneg");
    mul16(16'hFFFF, 16'hFFFF, "R4 -1x-1");
    mul16(16'h1234, 16'h5555, "R5 alternating 0101");
    mul16(16'hBEEF, 16'hAAAA, "R5 alternating 1010");
    mul16(16'h8000, 16'hAAAA, "R5 minneg x 1010");
    mul16(16'h0000, 16'hFFFF, "R4 zero");
    mul16(16'hFFEB, 16'h000E, "R4 -21x14");

    // R6: start while busy is ignored
    @(negedge clk); st16 = 1'b1; a16 = 16'd300; b16 = 16'hFF9C;
    @(negedge clk); a16 = 16'd7; b16 = 16'd9;
    @(negedge clk); st16 = 1'b0;
    repeat (7) @(negedge clk);
    chk(done16 == 1'b1, "R6 timing kept", 64'(done16), 64'd1);
    chk(p16 == ref16(16'd300, 16'hFF9C), "R6 operands kept", 64'(p16),
        64'(ref16(16'd300, 16'hFF9C)));
    @(negedge clk);
    chk(busy16 == 1'b0, "R6 no restart", 64'(busy16), 64'd0);

    // R7: idle inputs moving without start
    held = p16;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); a16 = 16'($urandom); b16 = 16'($urandom);
    end
    @(negedge clk);
    chk(p16 == held && busy16 == 1'b0, "R7 idle hold", 64'(p16), 64'(held));

    for (int k = 0; k < 300; k++) mul16(16'($urandom), 16'($urandom), "R4 random n16");

    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++) mul4(4'(x), 4'(y));

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule